// File: doc/BRIEF.md
# Multidrop Wake-Up Address Filter

This block sits between a UART receiver and its receive FIFO on one channel of a party-line serial bus. Each received character arrives as a one-cycle strobe. The strobe carries a data byte and a ninth bit taken from the parity position. When the frame-mode field selects wake-up operation, the ninth bit marks the character as an address (1) or as data (0). The block keeps the channel's receiver-enabled state. For each character it decides whether to push the character into the FIFO. It also decides whether to raise a ready flag that tells the host an address character has arrived.

Four submodes set who controls the receiver-enabled state. In submode 00 the host controls it alone: every address character is shown to the host, and the host enables or disables the receiver by command. In the automatic submodes, hardware compares each address character with the programmed station address. Submode 01 wakes the receiver on a match. Submode 10 puts it to sleep on a mismatch. Submode 11 does both. An address-load control bit chooses whether address characters in the automatic submodes reach the FIFO. The receiver keeps watching for address characters even while it is disabled.

When the frame mode is anything other than wake-up, the ninth bit has no meaning here. Characters then pass only while the receiver is enabled, and only the host commands change that state.

Top module: `mdrop_wake_filter`

## Requirements
- R1: After reset, rx_en_o, push_o and rxrdy_o are all 0.
- R2: With frame_mode_i not equal to 2'b11, a character is pushed exactly when rx_en_o is 1, whatever its ninth bit is, and rxrdy_o stays 0.
- R3: With frame_mode_i equal to 2'b11, a data character (char_adr_i = 0) is pushed when rx_en_o is 1 and dropped when rx_en_o is 0.
- R4: In wake-up mode with wake_sub_i = 2'b00, every address character (char_adr_i = 1) is pushed with rxrdy_o high in the same cycle, and rx_en_o does not change.
- R5: With wake_sub_i = 2'b01, an address character equal to station_adr_i sets rx_en_o to 1.
- R6: With wake_sub_i = 2'b10, an address character that differs from station_adr_i clears rx_en_o to 0.
- R7: With wake_sub_i = 2'b11, a matching address character sets rx_en_o and a differing one clears it.
- R8: In the automatic submodes (01, 10, 11), an address character is pushed only when adr_load_i is 1 and the receiver is enabled either before or after that character. A pushed address character raises rxrdy_o.
- R9: A differing address character under submode 01 leaves rx_en_o unchanged. A matching address character under submode 10 also leaves rx_en_o unchanged.
- R10: host_en_i sets rx_en_o and host_dis_i clears it. If both are high, host_dis_i wins. A host command takes priority over an automatic wake or doze decided in the same cycle.
- R11: A push appears on push_o one clock after the character strobe, as a single-cycle pulse. push_data_o then equals the character's data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| char_vld_i | input | 1 | One-cycle strobe: a received character is present |
| char_data_i | input | DW | Data byte of the received character |
| char_adr_i | input | 1 | Ninth bit: 1 marks an address character, 0 a data character |
| station_adr_i | input | DW | Station address used in the automatic submodes |
| frame_mode_i | input | 2 | Frame mode; 2'b11 selects wake-up operation |
| wake_sub_i | input | 2 | Submode: 00 host, 01 auto wake, 10 auto doze, 11 both |
| adr_load_i | input | 1 | In the automatic submodes, lets address characters reach the FIFO |
| host_en_i | input | 1 | Host command: enable the receiver |
| host_dis_i | input | 1 | Host command: disable the receiver |
| rx_en_o | output | 1 | Receiver-enabled state |
| push_o | output | 1 | FIFO push strobe |
| push_data_o | output | DW | Data byte pushed to the FIFO |
| rxrdy_o | output | 1 | Pulses when an address character is pushed in wake-up mode |

## Verification
A wrong enable state shows up at rx_en_o one clock after the character or command that caused it. It also shows up in the push decision for the very next data character. So a missed wake or doze is caught within two characters. A wrong classification of a character shows up at push_o and rxrdy_o one clock after its strobe. The directed scenarios therefore follow each address character with a data character. This shows both the state change and its effect on the data stream.

// File: rtl/mdw_pkg.sv
package mdw_pkg;

  localparam logic [1:0] FRAME_WAKEUP = 2'b11;

  typedef enum logic [1:0] {
    SUB_HOST = 2'b00,
    SUB_WAKE = 2'b01,
    SUB_DOZE = 2'b10,
    SUB_BOTH = 2'b11
  } mdw_sub_e;

  typedef struct packed {
    logic push;
    logic rdy;
    logic set_en;
    logic clr_en;
  } mdw_act_t;

endpackage

// File: rtl/mdw_rst_sync.sv
module mdw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/mdw_addr_cmp.sv
module mdw_addr_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] char_i,
  input  logic [DW-1:0] station_i,
  output logic          match_o
);
  logic [DW-1:0] bit_eq;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign bit_eq[b] = ~(char_i[b] ^ station_i[b]);
  end

  assign match_o = &bit_eq;
endmodule

// File: rtl/mdw_classify.sv
module mdw_classify
  import mdw_pkg::*;
(
  input  logic       vld_i,
  input  logic       adr_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] sub_i,
  input  logic       adr_load_i,
  input  logic       match_i,
  input  logic       en_q_i,
  output mdw_act_t   act_o
);
  logic wake_mode;
  logic en_after;

  assign wake_mode = (mode_i == FRAME_WAKEUP);

  always_comb begin
    act_o    = '0;
    en_after = en_q_i;
    if (vld_i) begin
      if (!wake_mode || !adr_i) begin
        // plain characters and data characters follow the enable state
        act_o.push = en_q_i;
      end else if (mdw_sub_e'(sub_i) == SUB_HOST) begin
        act_o.push = 1'b1;
        act_o.rdy  = 1'b1;
      end else begin
        act_o.set_en = sub_i[0] & match_i;
        act_o.clr_en = sub_i[1] & ~match_i;
        if (act_o.set_en)      en_after = 1'b1;
        else if (act_o.clr_en) en_after = 1'b0;
        act_o.push = adr_load_i & (en_q_i | en_after);
        act_o.rdy  = act_o.push;
      end
    end
  end
endmodule

// File: rtl/mdw_en_state.sv
module mdw_en_state (
  input  logic clk_i,
  input  logic rst_sn,
  input  logic host_en_i,
  input  logic host_dis_i,
  input  logic auto_set_i,
  input  logic auto_clr_i,
  output logic en_q_o
);
  logic en_d;
  logic en_q;

  always_comb begin
    en_d = en_q;
    if (host_dis_i)      en_d = 1'b0;
    else if (host_en_i)  en_d = 1'b1;
    else if (auto_set_i) en_d = 1'b1;
    else if (auto_clr_i) en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_q_o = en_q;
endmodule

// File: rtl/mdrop_wake_filter.sv
module mdrop_wake_filter
  import mdw_pkg::*;
#(
  parameter int DW         = 8,
  parameter int RST_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          char_vld_i,
  input  logic [DW-1:0] char_data_i,
  input  logic          char_adr_i,
  input  logic [DW-1:0] station_adr_i,
  input  logic [1:0]    frame_mode_i,
  input  logic [1:0]    wake_sub_i,
  input  logic          adr_load_i,
  input  logic          host_en_i,
  input  logic          host_dis_i,
  output logic          rx_en_o,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          rxrdy_o
);
  logic     rst_sn;
  logic     match;
  logic     en_q;
  mdw_act_t act;

  logic          push_d, push_q;
  logic          rdy_d, rdy_q;
  logic [DW-1:0] data_q;
  logic          data_ce;

  mdw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_sn(rst_sn)
  );

  mdw_addr_cmp #(.DW(DW)) u_cmp (
    .char_i   (char_data_i),
    .station_i(station_adr_i),
    .match_o  (match)
  );

  mdw_classify u_cls (
    .vld_i     (char_vld_i),
    .adr_i     (char_adr_i),
    .mode_i    (frame_mode_i),
    .sub_i     (wake_sub_i),
    .adr_load_i(adr_load_i),
    .match_i   (match),
    .en_q_i    (en_q),
    .act_o     (act)
  );

  mdw_en_state u_en (
    .clk_i     (clk_i),
    .rst_sn    (rst_sn),
    .host_en_i (host_en_i),
    .host_dis_i(host_dis_i),
    .auto_set_i(act.set_en),
    .auto_clr_i(act.clr_en),
    .en_q_o    (en_q)
  );

  always_comb begin
    push_d  = act.push;
    rdy_d   = act.rdy;
    data_ce = act.push;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      push_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      push_q <= push_d;
      rdy_q  <= rdy_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn)      data_q <= '0;
    else if (data_ce) data_q <= char_data_i;
  end

  assign rx_en_o     = en_q;
  assign push_o      = push_q;
  assign push_data_o = data_q;
  assign rxrdy_o     = rdy_q;
endmodule

// File: rtl/mdw_checker.sv
module mdw_checker #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_sn,
  input logic          char_vld_i,
  input logic [DW-1:0] char_data_i,
  input logic          char_adr_i,
  input logic [DW-1:0] station_adr_i,
  input logic [1:0]    frame_mode_i,
  input logic [1:0]    wake_sub_i,
  input logic          host_en_i,
  input logic          host_dis_i,
  input logic          rx_en_o,
  input logic          push_o,
  input logic [DW-1:0] push_data_o,
  input logic          rxrdy_o
);
  logic adr_ev;
  assign adr_ev = char_vld_i && char_adr_i && (frame_mode_i == 2'b11);

  p_push_after_char_r11: assert property (@(posedge clk_i) disable iff (!rst_sn)
    push_o |-> $past(char_vld_i));

  p_push_data_r11: assert property (@(posedge clk_i) disable iff (!rst_sn)
    push_o |-> (push_data_o == $past(char_data_i)));

  p_rdy_with_push_r4: assert property (@(posedge clk_i) disable iff (!rst_sn)
    rxrdy_o |-> push_o);

  p_rdy_wake_only_r2: assert property (@(posedge clk_i) disable iff (!rst_sn)
    rxrdy_o |-> ($past(frame_mode_i) == 2'b11));

  p_data_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (char_vld_i && !char_adr_i && (frame_mode_i == 2'b11) && !rx_en_o) |=> !push_o);

  p_auto_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (adr_ev && wake_sub_i[0] && (char_data_i == station_adr_i) && !host_dis_i) |=> rx_en_o);

  p_auto_doze_r6: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (adr_ev && wake_sub_i[1] && (char_data_i != station_adr_i) && !host_en_i) |=> !rx_en_o);

  p_dis_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_sn)
    host_dis_i |=> !rx_en_o);

  p_en_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (host_en_i && !host_dis_i) |=> rx_en_o);
endmodule

bind mdrop_wake_filter mdw_checker #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_sn       (rst_sn),
  .char_vld_i   (char_vld_i),
  .char_data_i  (char_data_i),
  .char_adr_i   (char_adr_i),
  .station_adr_i(station_adr_i),
  .frame_mode_i (frame_mode_i),
  .wake_sub_i   (wake_sub_i),
  .host_en_i    (host_en_i),
  .host_dis_i   (host_dis_i),
  .rx_en_o      (rx_en_o),
  .push_o       (push_o),
  .push_data_o  (push_data_o),
  .rxrdy_o      (rxrdy_o)
);

// File: tb/mdrop_wake_filter_tb_top.sv
module mdrop_wake_filter_tb_top;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          char_vld_i = 1'b0;
  logic [DW-1:0] char_data_i = '0;
  logic          char_adr_i = 1'b0;
  logic [DW-1:0] station_adr_i = 8'h5A;
  logic [1:0]    frame_mode_i = 2'b00;
  logic [1:0]    wake_sub_i = 2'b00;
  logic          adr_load_i = 1'b0;
  logic          host_en_i = 1'b0;
  logic          host_dis_i = 1'b0;
  logic          rx_en_o;
  logic          push_o;
  logic [DW-1:0] push_data_o;
  logic          rxrdy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mdrop_wake_filter #(.DW(DW)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .char_vld_i   (char_vld_i),
    .char_data_i  (char_data_i),
    .char_adr_i   (char_adr_i),
    .station_adr_i(station_adr_i),
    .frame_mode_i (frame_mode_i),
    .wake_sub_i   (wake_sub_i),
    .adr_load_i   (adr_load_i),
    .host_en_i    (host_en_i),
    .host_dis_i   (host_dis_i),
    .rx_en_o      (rx_en_o),
    .push_o       (push_o),
    .push_data_o  (push_data_o),
    .rxrdy_o      (rxrdy_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus. Outputs are registered, so they are
  // sampled at the following falling edge.
  task automatic step(input bit vld, input logic [7:0] d, input bit adr,
                      input bit hen, input bit hdis);
    @(negedge clk_i);
    char_vld_i  = vld;
    char_data_i = d;
    char_adr_i  = adr;
    host_en_i   = hen;
    host_dis_i  = hdis;
    @(negedge clk_i);
    char_vld_i = 1'b0;
    host_en_i  = 1'b0;
    host_dis_i = 1'b0;
  endtask

  task automatic send(input string req, input logic [7:0] d, input bit adr,
                      input bit exp_push, input bit exp_rdy, input bit exp_en);
    step(1'b1, d, adr, 1'b0, 1'b0);
    chk(req, "push", int'(push_o), int'(exp_push));
    if (exp_push) chk(req, "data", int'(push_data_o), int'(d));
    chk(req, "rxrdy", int'(rxrdy_o), int'(exp_rdy));
    chk(req, "rx_en", int'(rx_en_o), int'(exp_en));
    @(negedge clk_i);
    chk("R11", "single pulse", int'(push_o), 0);
  endtask

  task automatic host(input bit hen, input bit hdis, input bit exp_en);
    step(1'b0, 8'h00, 1'b0, hen, hdis);
    chk("R10", "host cmd rx_en", int'(rx_en_o), int'(exp_en));
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1", "rx_en", int'(rx_en_o), 0);
    chk("R1", "push", int'(push_o), 0);
    chk("R1", "rxrdy", int'(rxrdy_o), 0);
  endtask

  task automatic t_plain();
    frame_mode_i = 2'b00;
    send("R2", 8'h11, 1'b1, 0, 0, 0);
    host(1, 0, 1);
    send("R2", 8'h22, 1'b1, 1, 0, 1);
    send("R11", 8'hC3, 1'b0, 1, 0, 1);
    host(0, 1, 0);
  endtask

  task automatic t_host_sub();
    frame_mode_i = 2'b11;
    wake_sub_i   = 2'b00;
    send("R3", 8'h40, 1'b0, 0, 0, 0);
    send("R4", 8'h33, 1'b1, 1, 1, 0);
    host(1, 0, 1);
    send("R3", 8'h41, 1'b0, 1, 0, 1);
    send("R4", 8'h5A, 1'b1, 1, 1, 1);
    host(0, 1, 0);
  endtask

  task automatic t_wake_sub();
    wake_sub_i = 2'b01;
    adr_load_i = 1'b1;
    send("R9", 8'h33, 1'b1, 0, 0, 0);
    send("R5", 8'h5A, 1'b1, 1, 1, 1);
    send("R9", 8'h34, 1'b1, 1, 1, 1);
    send("R3", 8'h42, 1'b0, 1, 0, 1);
  endtask

  task automatic t_doze_sub();
    wake_sub_i = 2'b10;
    send("R9", 8'h5A, 1'b1, 1, 1, 1);
    adr_load_i = 1'b0;
    send("R6", 8'h35, 1'b1, 0, 0, 0);
    send("R3", 8'h43, 1'b0, 0, 0, 0);
    host(1, 0, 1);
    adr_load_i = 1'b1;
    send("R8", 8'h36, 1'b1, 1, 1, 0);
    send("R9", 8'h5A, 1'b1, 0, 0, 0);
  endtask

  task automatic t_both_sub();
    wake_sub_i = 2'b11;
    adr_load_i = 1'b0;
    send("R7", 8'h5A, 1'b1, 0, 0, 1);
    send("R3", 8'h44, 1'b0, 1, 0, 1);
    send("R7", 8'h37, 1'b1, 0, 0, 0);
    send("R3", 8'h45, 1'b0, 0, 0, 0);
  endtask

  task automatic t_priority();
    host(1, 1, 0);
    // mismatching address would doze, but the enable command wins
    step(1'b1, 8'h38, 1'b1, 1'b1, 1'b0);
    chk("R10", "host over doze rx_en", int'(rx_en_o), 1);
    chk("R10", "no push", int'(push_o), 0);
    // matching address would wake, but the disable command wins
    step(1'b1, 8'h5A, 1'b1, 1'b0, 1'b1);
    chk("R10", "host over wake rx_en", int'(rx_en_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_host_sub();
    t_wake_sub();
    t_doze_sub();
    t_both_sub();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule